// File: doc/BRIEF.md
# Hart Register Access Engine

This block lets an external debugger reach the registers of one hart without the hart's help. It does so through two words of the debug register space: a command word and a data word. The command word holds a target address and a direction bit. The data word is XLEN bits wide. The slave-port address decode is shared with the run-control logic, so this block does not decode addresses. It sees a write strobe and a select that picks one of the two words, and it returns both words for the shared read mux.

A nonzero write to the command word starts one access. The access goes out on a request port toward the hart's CSRs, program counters and integer registers. A read places the fetched value in the data word. A write copies the data word to the target. In both cases the engine then clears the command word, and the debugger polls until the command reads zero. Targets outside the defined ranges never reach the hart. Such a command completes on its own and, for a read, leaves zero in the data word.

The hart-side port is a valid/ready pair. Once `hreq_valid_o` rises, address, direction, kind and write data stay fixed until the hart returns a one-cycle `hrsp_ready_i`, which also carries the read data. The hart may hold the engine for any number of cycles. A ready pulse outside a request has no effect.

Top module: `hart_reg_access`

## Requirements
- R1: After reset the command word and the data word read zero and no hart request is pending.
- R2: Command word layout: bit 0 is the direction (0 read, 1 write) and bits 16:1 are the 16-bit target. Higher written bits are dropped and read back as zero. Writing an all-zero command starts nothing.
- R3: For a read, the engine raises a request with `hreq_write_o`=0 in the cycle after the command write. In the cycle after the hart's ready, the data word holds the returned value and the command word reads zero.
- R4: For a write, the request carries `hreq_write_o`=1 and the current data word on `hreq_wdata_o`. The data word is not changed, and the command word reads zero in the cycle after ready.
- R5: While the request waits for ready, it keeps valid, address, direction, kind and write data unchanged. A ready pulse with no request pending changes nothing.
- R6: `hreq_kind_o` encodes the target: 0 for a CSR (0x0000–0x0FFF), 1 for the current PC (0x1000), 2 for the next PC (0x1001), and 3 for an integer register (0x1010–0x102F, index = target − 0x1010).
- R7: Any other target is reserved and raises no request. The command word reads nonzero for one cycle and then zero. A reserved read sets the data word to zero, and a reserved write leaves it unchanged.
- R8: While an access is in progress, writes to the command word or to the data word are ignored.
- R9: While idle, the data word takes any value written to it and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Write strobe from the shared slave decode |
| reg_sel_i | input | 1 | Word select: 0 command, 1 data |
| reg_wdata_i | input | XLEN | Write value |
| cmd_rdata_o | output | XLEN | Command word read value |
| data_rdata_o | output | XLEN | Data word read value |
| hreq_valid_o | output | 1 | Hart access request |
| hreq_write_o | output | 1 | Request direction, 1 = write |
| hreq_addr_o | output | TGT_W | Target address |
| hreq_kind_o | output | 2 | Decoded target kind |
| hreq_wdata_o | output | XLEN | Value to write |
| hrsp_ready_i | input | 1 | One-cycle completion from the hart |
| hrsp_rdata_i | input | XLEN | Read value, valid with ready |

## Verification
The bench builds the block with XLEN = 32 and a 16-bit target field. With these values, a command word can carry a stray bit 31 and so test the truncation rule, and every range edge of the target decode can be reached: 0x0FFF, 0x1000, 0x1001, 0x1002, 0x102F, 0x1030 and 0x1100. The hart model varies its ready latency from zero to several cycles. This exercises the back-pressure hold and gives room to try command and data writes in the middle of an access.

// File: rtl/hra_pkg.sv
package hra_pkg;

  typedef enum logic [1:0] {
    TK_CSR = 2'd0,
    TK_PC  = 2'd1,
    TK_NPC = 2'd2,
    TK_GPR = 2'd3
  } tgt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FIN  = 2'd2
  } eng_state_e;

  localparam int unsigned CSR_LAST  = 32'h0000_0FFF;
  localparam int unsigned PC_TGT    = 32'h0000_1000;
  localparam int unsigned NPC_TGT   = 32'h0000_1001;
  localparam int unsigned GPR_BASE  = 32'h0000_1010;
  localparam int unsigned GPR_COUNT = 32;

endpackage

// File: rtl/hra_target_decode.sv
module hra_target_decode
  import hra_pkg::*;
#(
  parameter int unsigned TGT_W = 16
) (
  input  logic [TGT_W-1:0] tgt_i,
  output tgt_kind_e        kind_o,
  output logic             legal_o
);

  localparam logic [TGT_W-1:0] CSR_HI  = TGT_W'(CSR_LAST);
  localparam logic [TGT_W-1:0] PC_A    = TGT_W'(PC_TGT);
  localparam logic [TGT_W-1:0] NPC_A   = TGT_W'(NPC_TGT);
  localparam logic [TGT_W-1:0] GPR_LO  = TGT_W'(GPR_BASE);
  localparam logic [TGT_W-1:0] GPR_HI  = TGT_W'(GPR_BASE + GPR_COUNT - 1);

  always_comb begin
    kind_o  = TK_CSR;
    legal_o = 1'b0;
    if (tgt_i <= CSR_HI) begin
      kind_o  = TK_CSR;
      legal_o = 1'b1;
    end else if (tgt_i == PC_A) begin
      kind_o  = TK_PC;
      legal_o = 1'b1;
    end else if (tgt_i == NPC_A) begin
      kind_o  = TK_NPC;
      legal_o = 1'b1;
    end else if (tgt_i >= GPR_LO && tgt_i <= GPR_HI) begin
      kind_o  = TK_GPR;
      legal_o = 1'b1;
    end
  end

endmodule

// File: rtl/hra_cmd_regs.sv
module hra_cmd_regs #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned CMD_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_i,
  input  logic             wr_data_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             busy_i,
  input  logic             clr_cmd_i,
  input  logic             load_rsp_i,
  input  logic             load_zero_i,
  input  logic [XLEN-1:0]  rsp_data_i,
  output logic             start_o,
  output logic [CMD_W-1:0] cmd_q_o,
  output logic [XLEN-1:0]  data_q_o
);

  logic [CMD_W-1:0] cmd_in;
  logic             cmd_take;
  logic             data_take;

  assign cmd_in    = wdata_i[CMD_W-1:0];
  assign cmd_take  = wr_cmd_i && !busy_i;
  assign data_take = wr_data_i && !busy_i;
  assign start_o   = cmd_take && (cmd_in != '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmd_q_o <= '0;
    end else if (clr_cmd_i) begin
      cmd_q_o <= '0;
    end else if (cmd_take) begin
      cmd_q_o <= cmd_in;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      data_q_o <= '0;
    end else if (load_rsp_i) begin
      data_q_o <= rsp_data_i;
    end else if (load_zero_i) begin
      data_q_o <= '0;
    end else if (data_take) begin
      data_q_o <= wdata_i;
    end
  end

endmodule

// File: rtl/hra_engine.sv
module hra_engine
  import hra_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       start_legal_i,
  input  logic       cmd_write_i,
  input  logic       hrsp_ready_i,
  output logic       busy_o,
  output logic       req_o,
  output logic       clr_cmd_o,
  output logic       load_rsp_o,
  output logic       load_zero_o
);

  eng_state_e state_q, state_d;
  logic       done_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = start_legal_i ? ST_REQ : ST_FIN;
      ST_REQ:  if (hrsp_ready_i) state_d = ST_IDLE;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign done_req    = (state_q == ST_REQ) && hrsp_ready_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign req_o       = (state_q == ST_REQ);
  assign clr_cmd_o   = done_req || (state_q == ST_FIN);
  assign load_rsp_o  = done_req && !cmd_write_i;
  assign load_zero_o = (state_q == ST_FIN) && !cmd_write_i;

endmodule

// File: rtl/hart_reg_access.sv
module hart_reg_access
  import hra_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned TGT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [XLEN-1:0]  reg_wdata_i,
  output logic [XLEN-1:0]  cmd_rdata_o,
  output logic [XLEN-1:0]  data_rdata_o,
  output logic             hreq_valid_o,
  output logic             hreq_write_o,
  output logic [TGT_W-1:0] hreq_addr_o,
  output logic [1:0]       hreq_kind_o,
  output logic [XLEN-1:0]  hreq_wdata_o,
  input  logic             hrsp_ready_i,
  input  logic [XLEN-1:0]  hrsp_rdata_i
);

  localparam int unsigned CMD_W = TGT_W + 1;
  localparam int unsigned PAD_W = XLEN - CMD_W;

  logic [CMD_W-1:0] cmd_q;
  logic [XLEN-1:0]  data_q;
  logic             start, busy, req, clr_cmd, load_rsp, load_zero;
  logic             new_legal, cur_legal;
  tgt_kind_e        new_kind, cur_kind;

  hra_target_decode #(.TGT_W(TGT_W)) u_dec_new (
    .tgt_i  (reg_wdata_i[CMD_W-1:1]),
    .kind_o (new_kind),
    .legal_o(new_legal)
  );

  hra_target_decode #(.TGT_W(TGT_W)) u_dec_cur (
    .tgt_i  (cmd_q[CMD_W-1:1]),
    .kind_o (cur_kind),
    .legal_o(cur_legal)
  );

  hra_cmd_regs #(.XLEN(XLEN), .CMD_W(CMD_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cmd_i   (reg_wr_i && !reg_sel_i),
    .wr_data_i  (reg_wr_i && reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .clr_cmd_i  (clr_cmd),
    .load_rsp_i (load_rsp),
    .load_zero_i(load_zero),
    .rsp_data_i (hrsp_rdata_i),
    .start_o    (start),
    .cmd_q_o    (cmd_q),
    .data_q_o   (data_q)
  );

  hra_engine u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_legal_i(new_legal),
    .cmd_write_i  (cmd_q[0]),
    .hrsp_ready_i (hrsp_ready_i),
    .busy_o       (busy),
    .req_o        (req),
    .clr_cmd_o    (clr_cmd),
    .load_rsp_o   (load_rsp),
    .load_zero_o  (load_zero)
  );

  assign cmd_rdata_o  = {{PAD_W{1'b0}}, cmd_q};
  assign data_rdata_o = data_q;
  assign hreq_valid_o = req && cur_legal;
  assign hreq_write_o = cmd_q[0];
  assign hreq_addr_o  = cmd_q[CMD_W-1:1];
  assign hreq_kind_o  = cur_kind;
  assign hreq_wdata_o = data_q;

  logic unused_kind;
  assign unused_kind = ^new_kind;

endmodule

// File: rtl/hart_reg_access_chk.sv
module hart_reg_access_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned TGT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [XLEN-1:0]  cmd_rdata_o,
  input logic [XLEN-1:0]  data_rdata_o,
  input logic             hreq_valid_o,
  input logic             hreq_write_o,
  input logic [TGT_W-1:0] hreq_addr_o,
  input logic [XLEN-1:0]  hreq_wdata_o,
  input logic             hrsp_ready_i,
  input logic [XLEN-1:0]  hrsp_rdata_i
);

  AST_RESET_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cmd_rdata_o == '0 && data_rdata_o == '0 && !hreq_valid_o)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreq_valid_o && !hrsp_ready_i) |=>
      (hreq_valid_o && $stable(hreq_addr_o) && $stable(hreq_write_o) && $stable(hreq_wdata_o))); // R5

  AST_CMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreq_valid_o && hrsp_ready_i) |=> (cmd_rdata_o == '0 && !hreq_valid_o)); // R3

  AST_READ_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreq_valid_o && hrsp_ready_i && !hreq_write_o) |=> (data_rdata_o == $past(hrsp_rdata_i))); // R3

  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreq_valid_o && hreq_write_o) |=> $stable(data_rdata_o)); // R4

  AST_WRITE_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreq_valid_o && hreq_write_o) |-> (hreq_wdata_o == data_rdata_o)); // R4

  AST_RESERVED_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_valid_o |-> (hreq_addr_o < TGT_W'(32'h1100))); // R7

  AST_READ_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreq_valid_o && !hrsp_ready_i) |=> $stable(data_rdata_o)); // R8

endmodule

bind hart_reg_access hart_reg_access_chk #(.XLEN(XLEN), .TGT_W(TGT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_rdata_o (cmd_rdata_o),
  .data_rdata_o(data_rdata_o),
  .hreq_valid_o(hreq_valid_o),
  .hreq_write_o(hreq_write_o),
  .hreq_addr_o (hreq_addr_o),
  .hreq_wdata_o(hreq_wdata_o),
  .hrsp_ready_i(hrsp_ready_i),
  .hrsp_rdata_i(hrsp_rdata_i)
);

// File: tb/hart_reg_access_test.sv
module hart_reg_access_test;

  localparam int XLEN = 32;
  localparam int TGT_W = 16;
  localparam int NVEC = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic             reg_sel = 1'b0;
  logic [XLEN-1:0]  reg_wdata = '0;
  logic [XLEN-1:0]  cmd_rd, data_rd;
  logic             hv, hw;
  logic [TGT_W-1:0] ha;
  logic [1:0]       hk;
  logic [XLEN-1:0]  hwd;
  logic             hready = 1'b0;
  logic [XLEN-1:0]  hrdata = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hart_reg_access #(.XLEN(XLEN), .TGT_W(TGT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .cmd_rdata_o(cmd_rd), .data_rdata_o(data_rd),
    .hreq_valid_o(hv), .hreq_write_o(hw), .hreq_addr_o(ha), .hreq_kind_o(hk),
    .hreq_wdata_o(hwd), .hrsp_ready_i(hready), .hrsp_rdata_i(hrdata)
  );

  // hart model
  logic [XLEN-1:0] m_gpr [32];
  logic [XLEN-1:0] m_pc = 32'h8000_0100;
  logic [XLEN-1:0] m_npc = 32'h8000_0104;
  logic [15:0]     m_csr_a = 16'hFFFF;
  logic [XLEN-1:0] m_csr_v = '0;

  // {write, target, value, latency}
  localparam logic [52:0] VEC [NVEC] = '{
    {1'b1, 16'h1015, 32'hA5A5_1234, 4'd2},
    {1'b0, 16'h1015, 32'h0,         4'd0},
    {1'b0, 16'h1000, 32'h0,         4'd1},
    {1'b1, 16'h1001, 32'h1357_9BDF, 4'd3},
    {1'b0, 16'h1001, 32'h0,         4'd0},
    {1'b0, 16'h0305, 32'h0,         4'd2},
    {1'b1, 16'h0FFF, 32'h0BAD_F00D, 4'd1},
    {1'b0, 16'h0FFF, 32'h0,         4'd4},
    {1'b0, 16'h102F, 32'h0,         4'd0},
    {1'b0, 16'h1100, 32'h0,         4'd0},
    {1'b0, 16'h1002, 32'h0,         4'd0},
    {1'b1, 16'h1030, 32'h7777_0000, 4'd0}
  };

  function automatic int kind_of(input logic [15:0] t);
    if (t < 16'h1000) return 0;
    if (t == 16'h1000) return 1;
    if (t == 16'h1001) return 2;
    if (t >= 16'h1010 && t < 16'h1030) return 3;
    return -1;
  endfunction

  function automatic logic [XLEN-1:0] model_rd(input logic [15:0] t);
    case (kind_of(t))
      0: return (t == m_csr_a) ? m_csr_v : {16'hC500, t};
      1: return m_pc;
      2: return m_npc;
      3: return m_gpr[t - 16'h1010];
      default: return '0;
    endcase
  endfunction

  task automatic model_wr(input logic [15:0] t, input logic [XLEN-1:0] v);
    case (kind_of(t))
      0: begin m_csr_a = t; m_csr_v = v; end
      1: m_pc = v;
      2: m_npc = v;
      3: m_gpr[t - 16'h1010] = v;
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [XLEN-1:0] v);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_access(input logic wr, input logic [15:0] t,
                            input logic [XLEN-1:0] v, input int lat, input string req);
    logic [XLEN-1:0] d_before;
    logic [XLEN-1:0] exp_d;
    int k;
    if (wr) bus_wr(1'b1, v);
    d_before = data_rd;
    k = kind_of(t);
    bus_wr(1'b0, {15'h0, t, wr});
    if (k >= 0) begin
      check(hv === 1'b1, req, {31'b0, hv}, 32'd1);
      check(ha === t && hw === wr, req, {15'b0, ha, hw}, {15'b0, t, wr});
      check(hk === 2'(k), "R6", {30'b0, hk}, 32'(k));
      if (wr) check(hwd === v, "R4", hwd, v);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check(hv === 1'b1 && ha === t && hw === wr, "R5", {15'b0, ha, hw}, {15'b0, t, wr});
      end
      exp_d = wr ? d_before : model_rd(t);
      hready = 1'b1;
      hrdata = model_rd(t);
      if (wr) model_wr(t, hwd);
      @(negedge clk);
      hready = 1'b0;
      hrdata = 32'hDEAD_BEEF;
      check(cmd_rd === '0 && hv === 1'b0, req, cmd_rd, 32'd0);
      check(data_rd === exp_d, req, data_rd, exp_d);
    end else begin
      check(hv === 1'b0 && cmd_rd !== '0, "R7", {31'b0, hv}, 32'd0);
      @(negedge clk);
      exp_d = wr ? d_before : '0;
      check(cmd_rd === '0 && hv === 1'b0, "R7", cmd_rd, 32'd0);
      check(data_rd === exp_d, "R7", data_rd, exp_d);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_gpr[i] = 32'h1000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmd_rd === '0 && data_rd === '0 && hv === 1'b0, "R1", cmd_rd | data_rd, 32'd0);

    // vector table
    for (int n = 0; n < NVEC; n++) begin
      logic        vw;
      logic [15:0] vt;
      logic [31:0] vv;
      logic [3:0]  vl;
      {vw, vt, vv, vl} = VEC[n];
      run_access(vw, vt, vv, int'(vl), vw ? "R4" : "R3");
    end

    // R9: data word plain read/write while idle
    bus_wr(1'b1, 32'hCAFE_0001);
    check(data_rd === 32'hCAFE_0001, "R9", data_rd, 32'hCAFE_0001);

    // R2: zero command starts nothing
    bus_wr(1'b0, 32'h0);
    check(hv === 1'b0 && cmd_rd === '0, "R2", cmd_rd, 32'd0);
    check(data_rd === 32'hCAFE_0001, "R2", data_rd, 32'hCAFE_0001);

    // R2: upper bits dropped, read of PC with bit 31 set
    bus_wr(1'b0, 32'h8000_2000);
    check(cmd_rd === 32'h0000_2000, "R2", cmd_rd, 32'h0000_2000);
    check(hv === 1'b1 && hk === 2'd1 && hw === 1'b0, "R2", {30'b0, hk}, 32'd1);
    hready = 1'b1; hrdata = m_pc;
    @(negedge clk);
    hready = 1'b0;
    check(data_rd === m_pc && cmd_rd === '0, "R2", data_rd, m_pc);

    // R8: writes during a busy read are ignored
    bus_wr(1'b0, {15'h0, 16'h1013, 1'b0});
    bus_wr(1'b1, 32'h5555_AAAA);
    check(data_rd === m_pc, "R8", data_rd, m_pc);
    bus_wr(1'b0, {15'h0, 16'h1001, 1'b1});
    check(cmd_rd === {15'h0, 16'h1013, 1'b0} && ha === 16'h1013 && hw === 1'b0,
          "R8", cmd_rd, {15'h0, 16'h1013, 1'b0});
    hready = 1'b1; hrdata = m_gpr[3];
    @(negedge clk);
    hready = 1'b0;
    check(data_rd === m_gpr[3] && cmd_rd === '0, "R8", data_rd, m_gpr[3]);

    // R5: ready with no request changes nothing
    hready = 1'b1; hrdata = 32'h0F0F_0F0F;
    @(negedge clk);
    hready = 1'b0;
    check(data_rd === m_gpr[3] && cmd_rd === '0 && hv === 1'b0, "R5", data_rd, m_gpr[3]);

    // R3/R6: GPR 0 boundary, zero latency
    run_access(1'b0, 16'h1010, 32'h0, 0, "R3");

    // R1: reset mid-access clears everything
    bus_wr(1'b0, {15'h0, 16'h0001, 1'b0});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_rd === '0 && data_rd === '0 && hv === 1'b0, "R1", cmd_rd | data_rd, 32'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule